// File: doc/BRIEF.md
# Overlap-Save Streaming Frame Buffer

This block joins a sample-rate audio stream to a block transform engine that runs overlap-save filtering with a partitioned filter. On its input side it keeps a history of the incoming samples. Every time a hop of L−K new samples has arrived, it offers the newest L samples as one frame on an indexed read port. Consecutive frames therefore share K samples. The transform engine reads the frame at its own pace and then releases it.

On its output side the engine writes each L-point inverse-transform result into one of two result banks. The leading K points carry circular wrap-around and are dropped on write, so each bank holds only the trailing L−K points. A commit pulse hands the bank to the drain side, and the engine then fills the other bank. The drain side plays one kept sample out for every accepted input sample, so the output stream runs in lockstep with the input stream.

Sticky flags report an input frame that was replaced before its release, and an output strobe that found no committed bank. Frame length L and partition length K are parameters. The production setting is L = 8192 and K = 4096, and the bench uses L = 16 and K = 8.

Top module: `osb_frame_buffer`

## Requirements
- R1: `in_ready` is high whenever `rst_n` is high, and every cycle with `in_valid` and `in_ready` high appends `in_data` to the sample history.
- R2: One cycle after every (L−K)-th accepted sample, `frame_ready` is high and the offered frame holds the last L accepted samples, with index 0 the oldest and index L−1 the newest.
- R3: Frame positions older than the first sample accepted after reset read as zero, so indices 0 to K−1 of the first frame are zero.
- R4: `frame_data` returns the frame word at `frame_addr` one clock after the address is presented.
- R5: A `frame_release` pulse drops `frame_ready` on the next cycle, unless a new frame completes in that same cycle.
- R6: If a new frame completes while `frame_ready` is still high and no release arrives in that cycle, `in_overrun` goes high and stays high until reset, and the new frame replaces the old one.
- R7: A result write with `res_addr` below K is discarded. A write with `res_addr` from K to L−1 is stored at kept position `res_addr`−K.
- R8: `res_done` commits the bank being filled and moves filling to the other bank. `res_free` is low while that other bank is still committed or draining, and writes or commits made while `res_free` is low are ignored.
- R9: Each accepted input sample yields a one-cycle `out_valid` pulse on the next cycle. The pulses carry the kept points in index order, and banks are drained in the order they were committed.
- R10: A strobe that finds no committed bank outputs zero. After the first commit since reset, such a strobe also sets the sticky `out_underrun` flag.
- R11: During reset and right after it, `frame_ready`, `out_valid`, `in_overrun` and `out_underrun` are low, and `res_free` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted when high |
| in_data | input | DW | Input sample |
| frame_ready | output | 1 | A complete input frame is offered |
| frame_release | input | 1 | Engine is done with the offered frame |
| frame_addr | input | $clog2(L) | Frame read index |
| frame_data | output | DW | Frame word, one cycle after the address |
| res_we | input | 1 | Result point write enable |
| res_addr | input | $clog2(L) | Result point index, 0 to L−1 |
| res_data | input | DW | Result point value |
| res_done | input | 1 | Commit the bank being filled |
| res_free | output | 1 | The bank being filled may be written |
| out_valid | output | 1 | Output sample pulse |
| out_data | output | DW | Output sample |
| in_overrun | output | 1 | Sticky: a frame was replaced before its release |
| out_underrun | output | 1 | Sticky: a strobe found no committed bank after the first commit |

## Verification
`frame_ready`, `in_overrun`, `out_valid`, `out_data` and `out_underrun` all change at the clock edge that accepts the sample responsible for them. `frame_data` and `res_free` change at the edge that registers the address, release or commit. The bench drives every stimulus on a falling edge and holds it across one rising edge. It reads each result at the next falling edge, which is exactly one register stage after the stimulus. Expected frame contents come from a running sample counter in the bench, and expected output samples come from a fixed table of kept values.

// File: rtl/osb_pkg.sv
package osb_pkg;
   // Which of the two result banks a pointer refers to.
   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_e;

   function automatic bank_e other_bank(input bank_e b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction
endpackage

// File: rtl/osb_in_ring.sv
// Input history ring of L+H words. The offered frame is the L-word window
// ending at the newest sample; the next hop lands in the remaining H slots.
module osb_in_ring #(
   parameter int DW = 24,
   parameter int L  = 1024,
   parameter int K  = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DW-1:0]        wr_data,
   input  logic [$clog2(L)-1:0] rd_addr,
   output logic [DW-1:0]        rd_data,
   input  logic                 release_i,
   output logic                 frame_ready,
   output logic                 overrun
);
   localparam int H         = L - K;
   localparam int RING      = L + H;
   localparam int AW        = $clog2(RING);
   localparam int HCW       = $clog2(H);
   localparam int CW        = $clog2(L + 1);
   localparam bit RING_POW2 = (RING & (RING - 1)) == 0;

   logic [DW-1:0]  mem [RING];
   logic [AW-1:0]  wp, base;
   logic [AW-1:0]  wp_nx, base_nx, rd_phys;
   logic [AW:0]    s_wp, s_base, s_rd;
   logic [HCW-1:0] hop_cnt;
   logic [CW-1:0]  fill, fill_nx, frame_fill, lead_zeros;
   logic           swap;

   assign swap   = wr_en && (hop_cnt == HCW'(H - 1));
   assign s_wp   = {1'b0, wp} + (AW + 1)'(1);
   assign s_base = {1'b0, wp} + (AW + 1)'(H + 1);
   assign s_rd   = {1'b0, base} + (AW + 1)'(rd_addr);

   generate
      if (RING_POW2) begin : g_mask
         assign wp_nx   = s_wp[AW-1:0];
         assign base_nx = s_base[AW-1:0];
         assign rd_phys = s_rd[AW-1:0];
      end else begin : g_fold
         assign wp_nx   = (s_wp   >= (AW + 1)'(RING)) ? AW'(s_wp   - (AW + 1)'(RING)) : AW'(s_wp);
         assign base_nx = (s_base >= (AW + 1)'(RING)) ? AW'(s_base - (AW + 1)'(RING)) : AW'(s_base);
         assign rd_phys = (s_rd   >= (AW + 1)'(RING)) ? AW'(s_rd   - (AW + 1)'(RING)) : AW'(s_rd);
      end
   endgenerate

   assign fill_nx    = (fill == CW'(L)) ? fill : fill + CW'(1);
   assign lead_zeros = CW'(L) - frame_fill;

   // Storage: no reset, unwritten words are masked through frame_fill.
   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp          <= '0;
         base        <= '0;
         hop_cnt     <= '0;
         fill        <= '0;
         frame_fill  <= '0;
         frame_ready <= 1'b0;
         overrun     <= 1'b0;
         rd_data     <= '0;
      end else begin
         rd_data <= (CW'(rd_addr) < lead_zeros) ? '0 : mem[rd_phys];
         if (wr_en) begin
            wp      <= wp_nx;
            fill    <= fill_nx;
            hop_cnt <= swap ? '0 : hop_cnt + HCW'(1);
         end
         if (swap) begin
            base        <= base_nx;
            frame_fill  <= fill_nx;
            frame_ready <= 1'b1;
            if (frame_ready && !release_i) overrun <= 1'b1;
         end else if (release_i) begin
            frame_ready <= 1'b0;
         end
      end
   end

   p_release_drop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !swap) |=> !frame_ready);
   p_overrun_set_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (swap && frame_ready && !release_i) |=> (overrun && frame_ready));
   p_overrun_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

// File: rtl/osb_out_banks.sv
// Two result banks of H kept points each; one fills from the engine while
// the other drains one point per sample strobe.
module osb_out_banks
   import osb_pkg::*;
#(
   parameter int DW = 24,
   parameter int L  = 1024,
   parameter int K  = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_we,
   input  logic [$clog2(L)-1:0] res_addr,
   input  logic [DW-1:0]        res_data,
   input  logic                 res_done,
   output logic                 res_free,
   input  logic                 strobe,
   output logic                 out_valid,
   output logic [DW-1:0]        out_data,
   output logic                 underrun
);
   localparam int H  = L - K;
   localparam int IW = $clog2(L);
   localparam int KW = $clog2(H);

   logic [DW-1:0] bank [2][H];
   logic [1:0]    full, full_nx;
   bank_e         fill_sel, drain_sel;
   logic [KW-1:0] rd_ptr, kidx;
   logic          keep, last, primed;

   assign res_free = !full[fill_sel];
   assign keep     = res_addr >= IW'(K);
   assign kidx     = KW'(res_addr - IW'(K));
   assign last     = rd_ptr == KW'(H - 1);

   always_ff @(posedge clk) begin
      if (res_we && res_free && keep) bank[fill_sel][kidx] <= res_data;
   end

   always_comb begin
      full_nx = full;
      if (strobe && full[drain_sel] && last) full_nx[drain_sel] = 1'b0;
      if (res_done && !full[fill_sel])       full_nx[fill_sel]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full      <= '0;
         fill_sel  <= BANK_A;
         drain_sel <= BANK_A;
         rd_ptr    <= '0;
         primed    <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         underrun  <= 1'b0;
      end else begin
         full      <= full_nx;
         out_valid <= strobe;
         if (res_done && res_free) begin
            fill_sel <= other_bank(fill_sel);
            primed   <= 1'b1;
         end
         if (strobe) begin
            if (full[drain_sel]) begin
               out_data <= bank[drain_sel][rd_ptr];
               if (last) begin
                  rd_ptr    <= '0;
                  drain_sel <= other_bank(drain_sel);
               end else begin
                  rd_ptr <= rd_ptr + KW'(1);
               end
            end else begin
               out_data <= '0;
               if (primed) underrun <= 1'b1;
            end
         end
      end
   end

   p_pulse_follows_strobe_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(strobe));
   p_underrun_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> (out_valid && out_data == '0));
   p_underrun_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

// File: rtl/osb_frame_buffer.sv
module osb_frame_buffer #(
   parameter int DW = 24,
   parameter int L  = 1024,
   parameter int K  = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DW-1:0]        in_data,
   output logic                 frame_ready,
   input  logic                 frame_release,
   input  logic [$clog2(L)-1:0] frame_addr,
   output logic [DW-1:0]        frame_data,
   input  logic                 res_we,
   input  logic [$clog2(L)-1:0] res_addr,
   input  logic [DW-1:0]        res_data,
   input  logic                 res_done,
   output logic                 res_free,
   output logic                 out_valid,
   output logic [DW-1:0]        out_data,
   output logic                 in_overrun,
   output logic                 out_underrun
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("osb_frame_buffer: DW must be at least 1");
      end
      if (K < 1 || K > L - 2) begin : g_bad_k
         $error("osb_frame_buffer: K must lie in 1 .. L-2");
      end
   endgenerate

   logic accept;

   assign in_ready = rst_n;
   assign accept   = in_valid && in_ready;

   osb_in_ring #(.DW(DW), .L(L), .K(K)) u_in (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (accept),
      .wr_data     (in_data),
      .rd_addr     (frame_addr),
      .rd_data     (frame_data),
      .release_i   (frame_release),
      .frame_ready (frame_ready),
      .overrun     (in_overrun)
   );

   osb_out_banks #(.DW(DW), .L(L), .K(K)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_we    (res_we),
      .res_addr  (res_addr),
      .res_data  (res_data),
      .res_done  (res_done),
      .res_free  (res_free),
      .strobe    (accept),
      .out_valid (out_valid),
      .out_data  (out_data),
      .underrun  (out_underrun)
   );

   p_frame_after_accept_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_ready) |-> $past(accept));
   p_ready_in_reset_r1 : assert property (@(posedge clk)
      !rst_n |-> !in_ready);
endmodule

// File: tb/osb_frame_buffer_bench.sv
`timescale 1ns/1ps
module osb_frame_buffer_bench;
   localparam int DW = 16;
   localparam int L  = 16;
   localparam int K  = 8;
   localparam int IW = $clog2(L);

   // Expected output pulses while draining two committed banks, then one empty strobe.
   localparam logic [15:0] EXP_OUT [17] = '{
      16'h1008, 16'h1009, 16'h100A, 16'h100B, 16'h100C, 16'h100D, 16'h100E, 16'h100F,
      16'h2008, 16'h2009, 16'h200A, 16'h200B, 16'h200C, 16'h200D, 16'h200E, 16'h200F,
      16'h0000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [DW-1:0] in_data = '0;
   logic frame_ready;
   logic frame_release = 1'b0;
   logic [IW-1:0] frame_addr = '0;
   logic [DW-1:0] frame_data;
   logic res_we = 1'b0;
   logic [IW-1:0] res_addr = '0;
   logic [DW-1:0] res_data = '0;
   logic res_done = 1'b0;
   logic res_free;
   logic out_valid;
   logic [DW-1:0] out_data;
   logic in_overrun;
   logic out_underrun;

   int checks = 0;
   int errors = 0;
   int samp = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   osb_frame_buffer #(.DW(DW), .L(L), .K(K)) u_osb_frame_buffer (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .frame_ready(frame_ready), .frame_release(frame_release),
      .frame_addr(frame_addr), .frame_data(frame_data),
      .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
      .res_done(res_done), .res_free(res_free),
      .out_valid(out_valid), .out_data(out_data),
      .in_overrun(in_overrun), .out_underrun(out_underrun)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Push the next sample (value 0x100 + sample number); outputs sampled after the accepting edge.
   task automatic push();
      samp++;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(16'h0100 + samp);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [DW-1:0] v);
      @(negedge clk);
      frame_addr = IW'(idx);
      @(negedge clk);
      v = frame_data;
   endtask

   task automatic rel();
      @(negedge clk);
      frame_release = 1'b1;
      @(negedge clk);
      frame_release = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      res_we = 1'b1; res_addr = IW'(a); res_data = DW'(d);
      @(negedge clk);
      res_we = 1'b0;
   endtask

   task automatic commit();
      @(negedge clk);
      res_done = 1'b1;
      @(negedge clk);
      res_done = 1'b0;
   endtask

   // Frame whose newest sample is number newest: index i holds sample newest-L+1+i, zero if not yet sent.
   task automatic check_frame(input int newest, input string tag);
      logic [DW-1:0] v;
      for (int i = 0; i < L; i++) begin
         int s;
         int e;
         s = newest - L + 1 + i;
         e = (s < 1) ? 0 : 16'h0100 + s;
         rd(i, v);
         chk(v == DW'(e), tag, int'(v), e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R1 ready low in reset", int'(in_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(frame_ready == 1'b0, "R11 frame_ready", int'(frame_ready), 0);
      chk(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
      chk(res_free == 1'b1, "R11 res_free", int'(res_free), 1);
      chk(in_overrun == 1'b0 && out_underrun == 1'b0, "R11 flags",
          int'({in_overrun, out_underrun}), 0);
      chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

      // First hop: before any commit, strobes output zero without underrun (R10, R9)
      push();
      chk(out_valid == 1'b1, "R9 pulse", int'(out_valid), 1);
      chk(out_data == '0 && out_underrun == 1'b0, "R10 unprimed zero",
          int'({out_underrun, out_data}), 0);
      for (int n = 2; n <= 7; n++) push();
      chk(frame_ready == 1'b0, "R2 not yet ready", int'(frame_ready), 0);
      push();
      chk(frame_ready == 1'b1, "R2 ready after hop", int'(frame_ready), 1);
      check_frame(8, "R3 R4 first frame");
      rel();
      chk(frame_ready == 1'b0, "R5 release", int'(frame_ready), 0);

      for (int n = 9; n <= 16; n++) push();
      chk(frame_ready == 1'b1, "R2 second frame ready", int'(frame_ready), 1);
      check_frame(16, "R2 second frame");
      rel();

      // Two result frames; third is refused (R7, R8)
      for (int i = 0; i < L; i++) wr(i, 16'h1000 + i);
      commit();
      chk(res_free == 1'b1, "R8 second bank free", int'(res_free), 1);
      for (int i = 0; i < L; i++) wr(i, 16'h2000 + i);
      commit();
      chk(res_free == 1'b0, "R8 both banks busy", int'(res_free), 0);
      for (int i = 0; i < L; i++) wr(i, 16'h3000 + i);
      commit();

      // Table walk: kept points in order, banks in commit order, then underrun (R7 R9 R10)
      for (int t = 0; t < 17; t++) begin
         push();
         chk(out_valid == 1'b1, "R9 pulse per sample", int'(out_valid), 1);
         chk(out_data == EXP_OUT[t], "R7 R9 kept output", int'(out_data), int'(EXP_OUT[t]));
         if (t == 7) chk(res_free == 1'b1, "R8 free after drain", int'(res_free), 1);
         if (t < 16) chk(out_underrun == 1'b0, "R10 no underrun yet", int'(out_underrun), 0);
         else chk(out_underrun == 1'b1, "R10 underrun set", int'(out_underrun), 1);
         if (frame_ready) rel();
      end
      chk(in_overrun == 1'b0, "R6 no overrun when released", int'(in_overrun), 0);

      // Overrun: samples 34..48, frame at 40 never released (R6)
      for (int n = 34; n <= 40; n++) push();
      chk(frame_ready == 1'b1 && in_overrun == 1'b0, "R6 pending frame",
          int'({frame_ready, in_overrun}), 2);
      for (int n = 41; n <= 48; n++) push();
      chk(in_overrun == 1'b1 && frame_ready == 1'b1, "R6 overrun set",
          int'({frame_ready, in_overrun}), 3);
      check_frame(48, "R6 replaced frame");
      rel();
      chk(in_overrun == 1'b1 && frame_ready == 1'b0, "R6 sticky after release",
          int'({frame_ready, in_overrun}), 1);
      chk(out_underrun == 1'b1, "R10 sticky underrun", int'(out_underrun), 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule